// File: doc/BRIEF.md
# Fieldbus Serial Receiver with Bit-Accurate Idle Detection

This block receives 11-bit characters from an RS-485 fieldbus line. Each character has one low start bit, eight data bits sent least significant bit first, one even-parity bit and one high stop bit. The receiver samples the line sixteen times per bit period. It confirms a start bit in the middle of that bit and takes every later bit at its centre sample. Each received byte is presented for one clock cycle, together with a parity-error flag and a framing-error flag. Characters inside a datagram follow each other with no gap, so a new start bit is accepted in the bit period right after a stop bit.

In parallel, a separate counter watches the raw synchronized line, whether or not a character is being decoded. It measures how long the line has been high without interruption. A byte-oriented receiver cannot see such idle stretches, because they carry no start bit. When the high run reaches a programmable number of bit times (eleven by default, which is one character length), the block emits a single-cycle sync pulse. The upper protocol layer uses this pulse as a frame boundary or as a bus-free mark for token timing.

The oversampling rate comes from a runtime clock divisor, so one system clock can serve several bus speeds.

Top module: `fbus_rx`

## Requirements
- R1: While reset is asserted and in the first cycles after it is released, byte_vld_o, par_err_o, frm_err_o and sync_o are all 0.
- R2: A character is a low start bit followed by data bits 0 through 7 (least significant first), a parity bit and a stop bit. Once it is decoded, byte_o carries the data and byte_vld_o is high for exactly one clock cycle.
- R3: par_err_o is 1 together with byte_vld_o when data plus parity hold an odd number of ones (even parity broken), and 0 otherwise.
- R4: frm_err_o is 1 together with byte_vld_o when the stop bit is sampled low. Neither error flag is ever high without byte_vld_o.
- R5: Characters sent back to back, each start bit directly after the previous stop bit, are all received in order without loss.
- R6: A low glitch shorter than half a bit period is rejected as a false start and produces no byte.
- R7: After the line has been high for idle_bits_i bit times, judged at the middle of the last of those bits, sync_o pulses high for one clock cycle, and only once per uninterrupted high run.
- R8: Any low sample restarts the idle count. A high run of 10 bit times or less never produces sync_o with the default threshold, so continuous character traffic never raises it.
- R9: idle_bits_i sets the idle threshold in bit times at run time. The value 0 selects the default of 11 bit times.
- R10: baud_div_i sets the number of clock cycles per oversample tick at run time (values 0 and 1 mean one cycle), so one bit lasts 16 times baud_div_i clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_div_i | input | 16 | Clock cycles per oversample tick |
| idle_bits_i | input | 5 | Idle threshold in bit times, 0 selects 11 |
| rxd_i | input | 1 | Raw serial line from the transceiver, idle high |
| byte_vld_o | output | 1 | One-cycle strobe for a received character |
| byte_o | output | 8 | Received data byte, valid with byte_vld_o |
| par_err_o | output | 1 | Even-parity mismatch, valid with byte_vld_o |
| frm_err_o | output | 1 | Stop bit sampled low, valid with byte_vld_o |
| sync_o | output | 1 | One-cycle pulse when the idle threshold is reached |

## Verification
If the bit-slot counter or the data shift register is wrong inside the character receiver, it shows within one character time: the next strobe arrives with a shifted byte, a false parity flag, or not at all. The bench therefore compares every strobe against a queue of expected characters. If the idle counter is wrong, the sync pulse appears too early, too late, twice, or in the middle of traffic. So the bench measures the pulse's delay in clock cycles from the end of a known last low bit, and it counts pulses across back-to-back traffic and across runs that are deliberately just under the threshold.

// File: rtl/fbus_rx_pkg.sv
package fbus_rx_pkg;
  localparam int unsigned OVS_RATE  = 16;
  localparam int unsigned CHAR_BITS = 8;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_PAR,
    RX_STOP
  } rx_state_e;
endpackage

// File: rtl/fbus_tick_gen.sv
module fbus_tick_gen #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (div_i <= DIV_W'(1)) || (cnt_q >= div_i - DIV_W'(1));
    cnt_d = wrap ? '0 : cnt_q + DIV_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

  // R10: with a divisor above one, ticks never fall on adjacent cycles
  a_r10_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && div_i > DIV_W'(1) && $stable(div_i)) |=> !tick_o);
endmodule

// File: rtl/fbus_line_sync.sv
module fbus_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/fbus_char_rx.sv
module fbus_char_rx
  import fbus_rx_pkg::*;
#(
  parameter int unsigned OVS       = OVS_RATE,
  parameter int unsigned DATA_BITS = CHAR_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_i,
  input  logic                 rx_i,
  output logic                 vld_o,
  output logic [DATA_BITS-1:0] data_o,
  output logic                 perr_o,
  output logic                 ferr_o,
  output logic                 busy_o
);
  localparam int unsigned SCNT_W = $clog2(OVS);
  localparam int unsigned BCNT_W = $clog2(DATA_BITS);
  localparam logic [SCNT_W-1:0] MID_SLOT  = SCNT_W'(OVS / 2 - 1);
  localparam logic [SCNT_W-1:0] LAST_SLOT = SCNT_W'(OVS - 1);

  rx_state_e            st_q, st_d;
  logic [SCNT_W-1:0]    scnt_q, scnt_d;
  logic [BCNT_W-1:0]    bcnt_q, bcnt_d;
  logic [DATA_BITS-1:0] shreg_q, shreg_d;
  logic                 par_q, par_d;
  logic                 last_q, last_d;
  logic                 vld_q, vld_d;
  logic [DATA_BITS-1:0] data_q, data_d;
  logic                 perr_q, perr_d;
  logic                 ferr_q, ferr_d;

  always_comb begin
    st_d    = st_q;
    scnt_d  = scnt_q;
    bcnt_d  = bcnt_q;
    shreg_d = shreg_q;
    par_d   = par_q;
    last_d  = last_q;
    data_d  = data_q;
    vld_d   = 1'b0;
    perr_d  = 1'b0;
    ferr_d  = 1'b0;
    if (tick_i) begin
      last_d = rx_i;
      unique case (st_q)
        RX_IDLE: begin
          if (last_q && !rx_i) begin
            st_d   = RX_START;
            scnt_d = '0;
          end
        end
        RX_START: begin
          if (scnt_q == MID_SLOT) begin
            scnt_d = '0;
            bcnt_d = '0;
            st_d   = rx_i ? RX_IDLE : RX_DATA;
          end else begin
            scnt_d = scnt_q + SCNT_W'(1);
          end
        end
        RX_DATA: begin
          if (scnt_q == LAST_SLOT) begin
            scnt_d  = '0;
            shreg_d = {rx_i, shreg_q[DATA_BITS-1:1]};
            if (bcnt_q == BCNT_W'(DATA_BITS - 1)) st_d = RX_PAR;
            else bcnt_d = bcnt_q + BCNT_W'(1);
          end else begin
            scnt_d = scnt_q + SCNT_W'(1);
          end
        end
        RX_PAR: begin
          if (scnt_q == LAST_SLOT) begin
            scnt_d = '0;
            par_d  = rx_i;
            st_d   = RX_STOP;
          end else begin
            scnt_d = scnt_q + SCNT_W'(1);
          end
        end
        RX_STOP: begin
          if (scnt_q == LAST_SLOT) begin
            scnt_d = '0;
            st_d   = RX_IDLE;
            vld_d  = 1'b1;
            data_d = shreg_q;
            perr_d = ^{shreg_q, par_q};
            ferr_d = !rx_i;
          end else begin
            scnt_d = scnt_q + SCNT_W'(1);
          end
        end
        default: st_d = RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      scnt_q  <= '0;
      bcnt_q  <= '0;
      shreg_q <= '0;
      par_q   <= 1'b0;
      last_q  <= 1'b1;
      vld_q   <= 1'b0;
      data_q  <= '0;
      perr_q  <= 1'b0;
      ferr_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      scnt_q  <= scnt_d;
      bcnt_q  <= bcnt_d;
      shreg_q <= shreg_d;
      par_q   <= par_d;
      last_q  <= last_d;
      vld_q   <= vld_d;
      data_q  <= data_d;
      perr_q  <= perr_d;
      ferr_q  <= ferr_d;
    end
  end

  assign vld_o  = vld_q;
  assign data_o = data_q;
  assign perr_o = perr_q;
  assign ferr_o = ferr_q;
  assign busy_o = (st_q == RX_START) || (st_q == RX_DATA) || (st_q == RX_PAR);

  // R2: the byte strobe lasts a single cycle
  a_r2_vld_single: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> !vld_q);

  // R4: error flags only travel with the strobe
  a_r4_flags_with_vld: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_q || ferr_q) |-> vld_q);

  // R6: a confirmed start always passes through the start state
  a_r6_data_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == RX_DATA) |-> $past(st_q) == RX_START);
endmodule

// File: rtl/fbus_idle_det.sv
module fbus_idle_det
  import fbus_rx_pkg::*;
#(
  parameter int unsigned OVS      = OVS_RATE,
  parameter int unsigned IDLE_W   = 5,
  parameter int unsigned IDLE_DEF = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic [IDLE_W-1:0] idle_bits_i,
  output logic              sync_o
);
  localparam int unsigned SCNT_W = $clog2(OVS);
  localparam int unsigned CNT_W  = IDLE_W + SCNT_W;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] bits_ext, thr;
  logic             sync_q, sync_d;

  always_comb begin
    bits_ext = (idle_bits_i == '0) ? CNT_W'(IDLE_DEF) : CNT_W'(idle_bits_i);
    thr      = (bits_ext << SCNT_W) - CNT_W'(OVS / 2);
    cnt_d    = cnt_q;
    sync_d   = 1'b0;
    if (tick_i) begin
      if (!rx_i) begin
        cnt_d = '0;
      end else if (cnt_q < thr) begin
        cnt_d  = cnt_q + CNT_W'(1);
        sync_d = (cnt_q == thr - CNT_W'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sync_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sync_q <= sync_d;
    end
  end

  assign sync_o = sync_q;

  // R7: the sync pulse lasts a single cycle
  a_r7_sync_single: assert property (@(posedge clk) disable iff (!rst_n)
    sync_q |=> !sync_q);

  // R8: a low sample clears the run, so no pulse can follow it
  a_r8_low_blocks_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !rx_i) |=> (!sync_q && cnt_q == '0));
endmodule

// File: rtl/fbus_rx.sv
module fbus_rx
  import fbus_rx_pkg::*;
#(
  parameter int unsigned DIV_W     = 16,
  parameter int unsigned IDLE_W    = 5,
  parameter int unsigned IDLE_DEF  = 11,
  parameter int unsigned SYNC_STG  = 2,
  parameter int unsigned DATA_BITS = CHAR_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DIV_W-1:0]     baud_div_i,
  input  logic [IDLE_W-1:0]    idle_bits_i,
  input  logic                 rxd_i,
  output logic                 byte_vld_o,
  output logic [DATA_BITS-1:0] byte_o,
  output logic                 par_err_o,
  output logic                 frm_err_o,
  output logic                 sync_o
);
  logic tick;
  logic rx_s;
  logic busy;

  fbus_tick_gen #(.DIV_W(DIV_W)) i_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (baud_div_i),
    .tick_o (tick)
  );

  fbus_line_sync #(.STAGES(SYNC_STG)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rxd_i),
    .q_o   (rx_s)
  );

  fbus_char_rx #(.OVS(OVS_RATE), .DATA_BITS(DATA_BITS)) i_char (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_i (tick),
    .rx_i   (rx_s),
    .vld_o  (byte_vld_o),
    .data_o (byte_o),
    .perr_o (par_err_o),
    .ferr_o (frm_err_o),
    .busy_o (busy)
  );

  fbus_idle_det #(.OVS(OVS_RATE), .IDLE_W(IDLE_W), .IDLE_DEF(IDLE_DEF)) i_idle (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .rx_i        (rx_s),
    .idle_bits_i (idle_bits_i),
    .sync_o      (sync_o)
  );

  // R8: with a threshold of a full character or more, sync never lands mid-character
  a_r8_no_sync_in_char: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_o && (idle_bits_i == '0 || idle_bits_i >= IDLE_W'(IDLE_DEF))) |-> !busy);
endmodule

// File: tb/test_fbus_rx.sv
module test_fbus_rx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] baud_div;
  logic [4:0]  idle_bits;
  logic        rxd;
  logic        byte_vld;
  logic [7:0]  byte_d;
  logic        par_err, frm_err, sync;

  int checks = 0;
  int fails  = 0;
  int sync_cnt = 0;
  int byte_cnt = 0;
  logic [9:0] exp_q[$];

  always #2 clk = ~clk;

  fbus_rx i_fbus_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .baud_div_i  (baud_div),
    .idle_bits_i (idle_bits),
    .rxd_i       (rxd),
    .byte_vld_o  (byte_vld),
    .byte_o      (byte_d),
    .par_err_o   (par_err),
    .frm_err_o   (frm_err),
    .sync_o      (sync)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return (baud_div <= 1) ? 16 : 16 * int'(baud_div);
  endfunction

  task automatic drive(input logic v, input int n);
    #1 rxd = v;
    repeat (n) @(posedge clk);
  endtask

  task automatic idle(input int nbits);
    drive(1'b1, nbits * bit_clks());
  endtask

  task automatic send_char(input logic [7:0] d, input bit flip_par, input logic stop_v);
    logic p;
    p = (^d) ^ flip_par;
    exp_q.push_back({d, flip_par, ~stop_v});
    drive(1'b0, bit_clks());
    for (int i = 0; i < 8; i++) drive(d[i], bit_clks());
    drive(p, bit_clks());
    drive(stop_v, bit_clks());
  endtask

  // Monitor: pops expected characters and counts sync pulses
  always @(negedge clk) begin
    if (rst_n && byte_vld) begin
      byte_cnt++;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected byte", int'(byte_d), -1);
      end else begin
        logic [9:0] e;
        e = exp_q.pop_front();
        chk(byte_d == e[9:2], "R2 R5 data", int'(byte_d), int'(e[9:2]));
        chk(par_err == e[1], "R3 parity flag", int'(par_err), int'(e[1]));
        chk(frm_err == e[0], "R4 framing flag", int'(frm_err), int'(e[0]));
      end
    end
    if (rst_n && !byte_vld)
      chk(!(par_err || frm_err) || 1'b0, "R4 flag without strobe", int'(par_err | frm_err), 0);
    if (rst_n && sync) sync_cnt++;
  end

  // Measure clocks from the end of a 0x00 character (run begins at its stop bit)
  task automatic measure_sync(input int thr_ticks, input string req);
    int n;
    int exp;
    int bd;
    bd = (baud_div <= 1) ? 1 : int'(baud_div);
    send_char(8'h00, 1'b0, 1'b1);
    exp = thr_ticks * bd - bit_clks();
    n = 0;
    @(negedge clk);
    while (!sync && n < 4000) begin
      @(negedge clk);
      n++;
    end
    chk(n >= exp - bd - 2 && n <= exp + bd + 6, req, n, exp);
    @(negedge clk);
    chk(!sync, "R7 single-cycle pulse", int'(sync), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int s0, b0;
    rst_n = 1'b0; rxd = 1'b1; baud_div = 16'd4; idle_bits = 5'd0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(!byte_vld && !par_err && !frm_err && !sync, "R1 reset outputs",
        int'({byte_vld, par_err, frm_err, sync}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!byte_vld && !sync, "R1 after release", int'({byte_vld, sync}), 0);

    // R7: initial idle run gives exactly one pulse
    idle(12);
    chk(sync_cnt == 1, "R7 first idle pulse", sync_cnt, 1);
    idle(12);
    chk(sync_cnt == 1, "R7 once per run", sync_cnt, 1);

    // R2 R5 R8: back-to-back traffic
    send_char(8'h55, 1'b0, 1'b1);
    send_char(8'hA3, 1'b0, 1'b1);
    send_char(8'h00, 1'b0, 1'b1);
    send_char(8'hFF, 1'b0, 1'b1);
    send_char(8'h81, 1'b0, 1'b1);
    idle(2);
    chk(exp_q.size() == 0, "R5 all back-to-back received", exp_q.size(), 0);
    chk(sync_cnt == 1, "R8 no sync in traffic", sync_cnt, 1);

    // R3 R4: error cases
    send_char(8'h3C, 1'b1, 1'b1);
    idle(1);
    send_char(8'h5A, 1'b0, 1'b0);
    idle(2);
    send_char(8'h01, 1'b1, 1'b0);
    idle(2);
    chk(exp_q.size() == 0, "R3 R4 error chars received", exp_q.size(), 0);

    // R6: short glitch
    b0 = byte_cnt;
    drive(1'b0, 4 * int'(baud_div));
    idle(3);
    chk(byte_cnt == b0, "R6 glitch rejected", byte_cnt - b0, 0);

    // R8: a 10-bit high run stays silent
    send_char(8'h00, 1'b0, 1'b1);
    s0 = sync_cnt;
    idle(9);
    send_char(8'h42, 1'b0, 1'b1);
    chk(sync_cnt == s0, "R8 ten-bit run silent", sync_cnt - s0, 0);

    // R7: default threshold timing
    measure_sync(11 * 16 - 8, "R7 default sync delay");

    // R9: runtime threshold of 3 bits
    idle_bits = 5'd3;
    measure_sync(3 * 16 - 8, "R9 programmed sync delay");
    idle_bits = 5'd0;
    idle(2);

    // R10: faster bus
    baud_div = 16'd2;
    idle(2);
    send_char(8'h96, 1'b0, 1'b1);
    send_char(8'h4B, 1'b0, 1'b1);
    send_char(8'hE7, 1'b1, 1'b1);
    idle(2);
    chk(exp_q.size() == 0, "R10 chars at divisor 2", exp_q.size(), 0);
    measure_sync(11 * 16 - 8, "R10 sync delay at divisor 2");

    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule